// File: doc/BRIEF.md
# Windowed Watchdog with Key Servicing

This block watches that software keeps running on time. Software sets a coarse 12-bit start value, a window size and a reaction type, then arms the watchdog by writing a 32-bit magic word. From that point a down-counter runs once per clock, starting from the start value scaled up by a fixed shift. Software proves it is alive by writing a two-word key sequence to the key register. The key is only accepted while the counter is inside the open window at the end of the count.

A key sequence that completes too early, or a counter that reaches zero, raises the selected reaction. The reaction is either a reset request that stays set until system reset, or a non-maskable interrupt level that software clears through the status flags. Once armed, the watchdog cannot be stopped, and its configuration is frozen until the next reset. Access is through a simple single-cycle register bus with combinational read data.

Top module: `wdgTop`

## Requirements
- R1: After reset the control register (0x90) reads 0, status (0x98) reads 0, the counter (0xA0) reads 0 and both reaction outputs are low. Key writes made while the watchdog is unarmed change neither status nor counter.
- R2: Only a write of 0xA98559DA to 0x90 arms the watchdog, and any other word leaves it unarmed. While armed, 0x90 reads 0xA98559DA, and no write disarms it.
- R3: The preload (0x94, bits 11:0), reaction (0xA4) and window (0xA8) registers are writable before arming. After arming, writes to them leave their read values unchanged.
- R4: The arming write loads the counter with preload << PRELOAD_SHIFT. After that the counter drops by one on each clock, and its value reads back at 0xA0.
- R5: Writing 0xE51A and then 0xA35C to the key register (0x9C) reloads the counter with the scaled preload when the window is open. While waiting for the first word, any other word is ignored. While waiting for the second word, another 0xE51A restarts the wait.
- R6: While waiting for the second word, a word other than 0xA35C or 0xE51A sets status bit 2 (bad key). The counter is not reloaded and the tracker returns to waiting for the first word. A bad key raises no reaction.
- R7: The window code 0x50 opens the window while the counter is below half the scaled preload. The code 0x500 opens it below one quarter. Any other code leaves the window open at all times.
- R8: A completed key sequence while the window is closed sets status bit 0 (violation) and does not reload the counter.
- R9: While armed, a clock edge with the counter at zero sets status bit 1 (expiry) and reloads the counter with the scaled preload.
- R10: The status bits 2:0 are sticky. Writing 1 to a bit of 0x98 clears it.
- R11: With the reaction register at 0xA, nmiReq is high while status bit 0 or 1 is set, and rstReq stays low. With any other reaction value, a violation or expiry sets rstReq, which stays high until reset even after the status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| rstReq | output | 1 | Sticky reset request |
| nmiReq | output | 1 | Non-maskable interrupt level |

## Verification
The bench builds the block with PRELOAD_SHIFT set to 4 and keeps PRELOAD_W at 12. A full count then lasts tens to a few thousand cycles instead of millions. This puts expiry, both window thresholds and the point where the window opens within a short run. These edges are checked to the exact cycle with small preloads of 2 and 5. A longer preload of 100 gives a random key-write phase room to run against a cycle-accurate bench model of the counter and the key tracker.

// File: rtl/wdgPkg.sv
package wdgPkg;

  localparam logic [7:0] OFF_CTRL    = 8'h90;
  localparam logic [7:0] OFF_PRELOAD = 8'h94;
  localparam logic [7:0] OFF_STATUS  = 8'h98;
  localparam logic [7:0] OFF_KEY     = 8'h9C;
  localparam logic [7:0] OFF_COUNT   = 8'hA0;
  localparam logic [7:0] OFF_REACT   = 8'hA4;
  localparam logic [7:0] OFF_WINDOW  = 8'hA8;

  localparam logic [31:0] ARM_WORD    = 32'hA98559DA;
  localparam logic [31:0] KEY_FIRST   = 32'h0000E51A;
  localparam logic [31:0] KEY_SECOND  = 32'h0000A35C;
  localparam logic [31:0] NMI_CODE    = 32'h0000000A;
  localparam logic [31:0] WIN_HALF    = 32'h00000050;
  localparam logic [31:0] WIN_QUARTER = 32'h00000500;

  typedef enum logic [1:0] {
    WSEL_FULL    = 2'd0,
    WSEL_HALF    = 2'd1,
    WSEL_QUARTER = 2'd2
  } winSel_t;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_WAIT2 = 1'b1
  } keyState_t;

  typedef struct packed {
    logic load;
    logic run;
  } dpStrobe_t;

endpackage

// File: rtl/wdgDatapath.sv
module wdgDatapath
  import wdgPkg::*;
#(
  parameter int PRELOAD_W     = 12,
  parameter int PRELOAD_SHIFT = 13,
  localparam int CNT_W        = PRELOAD_W + PRELOAD_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [PRELOAD_W-1:0] preload,
  input  winSel_t              winSel,
  output logic [CNT_W-1:0]     count,
  output logic                 atZero,
  output logic                 windowOpen
);

  logic [CNT_W-1:0] startVal;
  logic [CNT_W-1:0] halfMark;
  logic [CNT_W-1:0] quarterMark;

  assign startVal    = {preload, {PRELOAD_SHIFT{1'b0}}};
  assign halfMark    = startVal >> 1;
  assign quarterMark = startVal >> 2;
  assign atZero      = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobe.load) begin
      count <= startVal;
    end else if (strobe.run) begin
      count <= count - 1'b1;
    end
  end

  always_comb begin
    case (winSel)
      WSEL_HALF:    windowOpen = (count < halfMark);
      WSEL_QUARTER: windowOpen = (count < quarterMark);
      default:      windowOpen = 1'b1;
    endcase
  end

  p_reload_value_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> count == $past(startVal));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run && !strobe.load) |=> count == CNT_W'($past(count) - 1'b1));

endmodule

// File: rtl/wdgCtrl.sv
module wdgCtrl
  import wdgPkg::*;
#(
  parameter int PRELOAD_W     = 12,
  parameter int PRELOAD_SHIFT = 13,
  localparam int CNT_W        = PRELOAD_W + PRELOAD_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [7:0]           busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [CNT_W-1:0]     count,
  input  logic                 atZero,
  input  logic                 windowOpen,
  output dpStrobe_t            strobe,
  output logic [PRELOAD_W-1:0] preload,
  output winSel_t              winSel,
  output logic                 rstReq,
  output logic                 nmiReq
);

  logic             armed;
  logic [31:0]      reactReg;
  logic [31:0]      winReg;
  logic [2:0]       status;
  logic [2:0]       statusNext;
  keyState_t        keyState;
  keyState_t        keyNext;

  logic wrCtrl, wrPre, wrStat, wrKey, wrReact, wrWin;
  logic armEvt, keyWr, svcAttempt, svcOk, violEvt, expEvt, badKeyEvt;
  logic nmiMode;
  logic [2:0] clearMask;

  always_comb begin
    wrCtrl  = busSel && busWr && (busAddr == OFF_CTRL);
    wrPre   = busSel && busWr && (busAddr == OFF_PRELOAD);
    wrStat  = busSel && busWr && (busAddr == OFF_STATUS);
    wrKey   = busSel && busWr && (busAddr == OFF_KEY);
    wrReact = busSel && busWr && (busAddr == OFF_REACT);
    wrWin   = busSel && busWr && (busAddr == OFF_WINDOW);
  end

  assign armEvt  = wrCtrl && (busWdata == ARM_WORD) && !armed;
  assign nmiMode = (reactReg == NMI_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      preload  <= '0;
      reactReg <= '0;
      winReg   <= '0;
    end else begin
      if (armEvt) armed <= 1'b1;
      if (!armed) begin
        if (wrPre)   preload  <= busWdata[PRELOAD_W-1:0];
        if (wrReact) reactReg <= busWdata;
        if (wrWin)   winReg   <= busWdata;
      end
    end
  end

  always_comb begin
    if (winReg == WIN_HALF)         winSel = WSEL_HALF;
    else if (winReg == WIN_QUARTER) winSel = WSEL_QUARTER;
    else                            winSel = WSEL_FULL;
  end

  // Key sequence tracker
  assign keyWr      = wrKey && armed;
  assign svcAttempt = keyWr && (keyState == KEY_WAIT2) && (busWdata == KEY_SECOND);
  assign badKeyEvt  = keyWr && (keyState == KEY_WAIT2) &&
                      (busWdata != KEY_SECOND) && (busWdata != KEY_FIRST);
  assign svcOk      = svcAttempt && windowOpen;
  assign violEvt    = svcAttempt && !windowOpen;
  assign expEvt     = armed && atZero;

  always_comb begin
    keyNext = keyState;
    if (keyWr) begin
      if (busWdata == KEY_FIRST) keyNext = KEY_WAIT2;
      else                       keyNext = KEY_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) keyState <= KEY_IDLE;
    else       keyState <= keyNext;
  end

  always_comb begin
    strobe.load = armEvt || svcOk || expEvt;
    strobe.run  = armed;
  end

  // Sticky status with write-one-to-clear
  assign clearMask  = wrStat ? busWdata[2:0] : 3'b000;
  assign statusNext = (status & ~clearMask) | {badKeyEvt, expEvt, violEvt};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      rstReq <= 1'b0;
    end else begin
      status <= statusNext;
      if ((violEvt || expEvt) && !nmiMode) rstReq <= 1'b1;
    end
  end

  assign nmiReq = nmiMode && (status[0] || status[1]);

  always_comb begin
    case (busAddr)
      OFF_CTRL:    busRdata = armed ? ARM_WORD : 32'h0;
      OFF_PRELOAD: busRdata = 32'(preload);
      OFF_STATUS:  busRdata = 32'(status);
      OFF_COUNT:   busRdata = 32'(count);
      OFF_REACT:   busRdata = reactReg;
      OFF_WINDOW:  busRdata = winReg;
      default:     busRdata = 32'h0;
    endcase
  end

  p_stays_armed_r2: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

  p_config_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> ($stable(preload) && $stable(reactReg) && $stable(winReg)));

  p_viol_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    violEvt |=> status[0]);

  p_expiry_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    expEvt |=> status[1]);

  p_rst_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq);

  p_nmi_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(nmiReq && rstReq && nmiMode && $rose(rstReq)));

endmodule

// File: rtl/wdgTop.sv
module wdgTop
  import wdgPkg::*;
#(
  parameter int PRELOAD_W     = 12,
  parameter int PRELOAD_SHIFT = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        rstReq,
  output logic        nmiReq
);

  localparam int CNT_W = PRELOAD_W + PRELOAD_SHIFT;

  dpStrobe_t            strobe;
  logic [PRELOAD_W-1:0] preload;
  winSel_t              winSel;
  logic [CNT_W-1:0]     count;
  logic                 atZero;
  logic                 windowOpen;

  wdgCtrl #(
    .PRELOAD_W    (PRELOAD_W),
    .PRELOAD_SHIFT(PRELOAD_SHIFT)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .count     (count),
    .atZero    (atZero),
    .windowOpen(windowOpen),
    .strobe    (strobe),
    .preload   (preload),
    .winSel    (winSel),
    .rstReq    (rstReq),
    .nmiReq    (nmiReq)
  );

  wdgDatapath #(
    .PRELOAD_W    (PRELOAD_W),
    .PRELOAD_SHIFT(PRELOAD_SHIFT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .preload   (preload),
    .winSel    (winSel),
    .count     (count),
    .atZero    (atZero),
    .windowOpen(windowOpen)
  );

endmodule

// File: tb/tb_wdgTop.sv
module tb_wdgTop;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT      = 4;

  localparam logic [7:0] A_CTRL = 8'h90, A_PRE = 8'h94, A_STAT = 8'h98,
                         A_KEY = 8'h9C, A_CNT = 8'hA0, A_REACT = 8'hA4,
                         A_WIN = 8'hA8;
  localparam logic [31:0] ARM = 32'hA98559DA, K1 = 32'hE51A, K2 = 32'hA35C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h0;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        rstReq, nmiReq;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdgTop #(.PRELOAD_W(12), .PRELOAD_SHIFT(SHIFT)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rstReq(rstReq), .nmiReq(nmiReq)
  );

  function automatic logic [31:0] scaled(input logic [31:0] pre);
    return pre << SHIFT;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog timeout (all requirements): actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] mCnt, mStat, w, start;
    logic        mWait2;
    void'($urandom(32'd20240611));
    doReset();

    // ---------------- Phase 1: NMI reaction, half window, preload 5
    readCheck("R1 ctrl", A_CTRL, 32'h0);
    readCheck("R1 status", A_STAT, 32'h0);
    readCheck("R1 count", A_CNT, 32'h0);
    check("R1 outputs", {30'h0, rstReq, nmiReq}, 32'h0);

    busWrite(A_PRE, 32'h5);
    busWrite(A_REACT, 32'hA);
    busWrite(A_WIN, 32'h50);
    readCheck("R3 preload before arm", A_PRE, 32'h5);
    readCheck("R3 window before arm", A_WIN, 32'h50);
    busWrite(A_CTRL, 32'h12345678);
    readCheck("R2 wrong arm word", A_CTRL, 32'h0);
    busWrite(A_CTRL, ARM);
    readCheck("R2 armed readback", A_CTRL, ARM);
    readCheck("R4 start value", A_CNT, scaled(5));           // 80
    busWrite(A_PRE, 32'h7);                                   // 79
    readCheck("R3 preload locked", A_PRE, 32'h5);
    busWrite(A_KEY, K1);                                      // 78
    busWrite(A_KEY, K2);                                      // at 78 closed -> 77
    readCheck("R8 violation flag", A_STAT, 32'h1);
    readCheck("R8 no reload", A_CNT, 32'd77);
    check("R11 nmi level", {30'h0, rstReq, nmiReq}, 32'h1);
    busWrite(A_STAT, 32'h1);                                  // 76
    readCheck("R10 w1c", A_STAT, 32'h0);
    check("R11 nmi drops", {31'h0, nmiReq}, 32'h0);
    busWrite(A_CTRL, 32'h0);                                  // 75
    readCheck("R2 no disarm", A_CTRL, ARM);
    idle(39);                                                 // 36
    readCheck("R4 decrement", A_CNT, 32'd36);
    busWrite(A_KEY, K1);                                      // 35
    busWrite(A_KEY, K2);                                      // at 35 open -> 80
    readCheck("R5 service reload", A_CNT, scaled(5));
    readCheck("R7 half window open", A_STAT, 32'h0);
    busWrite(A_KEY, K1);                                      // 79
    busWrite(A_KEY, 32'h1234);                                // 78
    readCheck("R6 bad key flag", A_STAT, 32'h4);
    readCheck("R6 no reload", A_CNT, 32'd78);
    check("R6 no reaction", {30'h0, rstReq, nmiReq}, 32'h0);
    busWrite(A_STAT, 32'h4);                                  // 77
    idle(40);                                                 // 37
    busWrite(A_KEY, K2);                                      // 36 ignored
    busWrite(A_KEY, K1);                                      // 35
    busWrite(A_KEY, K1);                                      // 34 restart
    busWrite(A_KEY, K2);                                      // at 34 -> 80
    readCheck("R5 order and restart", A_CNT, scaled(5));
    readCheck("R5 status clean", A_STAT, 32'h0);
    idle(80);
    readCheck("R9 at zero", A_CNT, 32'h0);
    readCheck("R9 no flag yet", A_STAT, 32'h0);
    idle(1);
    readCheck("R9 expiry flag", A_STAT, 32'h2);
    readCheck("R9 reload", A_CNT, scaled(5));
    check("R11 nmi on expiry", {30'h0, rstReq, nmiReq}, 32'h1);

    // ---------------- Phase 2: reset reaction, quarter window, preload 2
    doReset();
    readCheck("R1 ctrl after reset", A_CTRL, 32'h0);
    busWrite(A_KEY, K1);
    busWrite(A_KEY, K2);
    readCheck("R1 unarmed key status", A_STAT, 32'h0);
    readCheck("R1 unarmed key count", A_CNT, 32'h0);
    busWrite(A_PRE, 32'h2);
    busWrite(A_REACT, 32'h5);
    busWrite(A_WIN, 32'h500);
    busWrite(A_CTRL, ARM);                                    // 32
    readCheck("R4 start quarter", A_CNT, scaled(2));
    idle(20);                                                 // 12
    busWrite(A_KEY, K1);                                      // 11
    busWrite(A_KEY, K2);                                      // at 11 closed -> 10
    readCheck("R7 quarter closed", A_STAT, 32'h1);
    check("R11 reset request", {30'h0, rstReq, nmiReq}, 32'h2);
    busWrite(A_STAT, 32'h7);                                  // 9
    readCheck("R10 cleared", A_STAT, 32'h0);
    check("R11 rst sticky", {31'h0, rstReq}, 32'h1);
    idle(3);                                                  // 6
    busWrite(A_KEY, K1);                                      // 5
    busWrite(A_KEY, K2);                                      // at 5 open -> 32
    readCheck("R7 quarter open", A_CNT, scaled(2));
    readCheck("R7 quarter ok status", A_STAT, 32'h0);

    // ---------------- Phase 3: random key traffic, full window, preload 100
    doReset();
    busWrite(A_PRE, 32'd100);
    busWrite(A_WIN, 32'h77);
    busWrite(A_CTRL, ARM);
    start = scaled(100);
    mCnt = start; mStat = 0; mWait2 = 1'b0;
    for (int i = 0; i < 300; i++) begin
      int unsigned op;
      logic doWr, svc, bad;
      op = $urandom % 4;
      doWr = 1'b1;
      case (op)
        0: w = K1;
        1: w = K2;
        2: w = $urandom;
        default: begin w = 32'h0; doWr = 1'b0; end
      endcase
      svc = doWr && mWait2 && (w == K2);
      bad = doWr && mWait2 && (w != K2) && (w != K1);
      if (mCnt == 0) mStat = mStat | 32'h2;
      if (bad) mStat = mStat | 32'h4;
      mCnt = ((mCnt == 0) || svc) ? start : mCnt - 1;
      if (doWr) mWait2 = (w == K1);
      if (doWr) busWrite(A_KEY, w);
      else      idle(1);
      readCheck("R5 random count", A_CNT, mCnt);
      readCheck("R6 random status", A_STAT, mStat);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule